// File: doc/BRIEF.md
# I2C Configuration Register Target

This block lets an external I2C controller read and write a small bank of 8-bit configuration registers. It oversamples the SCL and SDA lines with the system clock and recognises start, repeated-start and stop conditions. It answers one 7-bit device address and shifts every field most significant bit first. It pulls SDA low through an output-enable signal, so the pad outside the block can be open drain.

A write names the register in a pointer byte and then sends one data byte. A read sends the pointer in a write-direction phase, issues a repeated start, re-addresses the device in read direction and receives one byte. The pointer survives repeated starts and never advances by itself. The same register can therefore be polled again and again without resending the pointer. After a read, a repeated start can also open a write. The register contents are visible to the surrounding logic as one flat vector.

Top module: `i2c_cfg_target`

## Requirements
- R1: After reset every register holds 0x00, the SDA output enable is 0 (line released) and the pointer is 0.
- R2: The device address is {1,0,0,1,0,0,addr_sel}. The address byte is this address followed by the R/W bit (0 = write, 1 = read), all MSB first. On a match the target holds sda_oe at 1 while SCL is high in the ninth clock.
- R3: For an address that does not match, the target gives no acknowledge. It keeps sda_oe at 0 and ignores all further bytes until the next start condition, so the registers do not change.
- R4: A write is the address with R/W = 0, a pointer byte and a data byte, and the target acknowledges each of them. The data byte is stored into the register the pointer selects once its eighth bit has been sampled.
- R5: A read is the address with R/W = 0, a pointer byte, a repeated start and the address with R/W = 1. The target then sends the selected register MSB first: sda_oe is 1 for a 0 bit and 0 for a 1 bit.
- R6: The pointer is kept across repeated starts and is not incremented. A repeated start followed by the read address returns the same register again.
- R7: SDA falling while SCL is high is a start, and SDA rising while SCL is high is a stop. A stop in the middle of a byte abandons the transaction, releases SDA and changes no register.
- R8: A pointer value of NUM_REGS or more reads as 0x00, and a write through such a pointer changes no register. The target still acknowledges the pointer and data bytes.
- R9: A data bit driven by the target changes only after an SCL falling edge and stays constant while SCL is high.
- R10: After a read, a repeated start followed by a write-direction address, pointer and data performs a normal write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| addr_sel | input | 1 | Sets the least significant bit of the device address |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_regs | output | NUM_REGS*8 | Register contents, register i in bits [8i+7:8i] |

## Verification
The bench checks that the address-select pin really moves the matched address: with the pin at 1, the 0 address must go unacknowledged. A design with a hard-wired LSB would acknowledge both addresses. It re-reads through repeated starts without resending the pointer; a target that clears or increments the pointer would return another register. Pointers past the bank must read zero and must not store anything, which catches index wrap-around. A stop in the middle of a byte and a foreign address both have to leave the bank untouched. This catches a target that commits or acknowledges on partial or stale state. Read bits are sampled twice in each SCL high phase to catch output that changes on the rising edge.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    localparam int BYTE_W = 8;
    localparam logic [5:0] ADDR_PREFIX = 6'b100100;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } tgt_state_e;

    typedef struct packed {
        logic scl_hi;
        logic scl_rise;
        logic scl_fall;
        logic sda_bit;
        logic start_ev;
        logic stop_ev;
    } bus_evt_t;

    function automatic logic addr_match(input logic [6:0] a, input logic sel);
        return a == {ADDR_PREFIX, sel};
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] cur;
    logic [NLINES-1:0] prev;

    assign raw = {scl_in, sda_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [SYNC_STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain   <= '1;
                prev[g] <= 1'b1;
            end else begin
                chain   <= {chain[SYNC_STAGES-2:0], raw[g]};
                prev[g] <= chain[SYNC_STAGES-1];
            end
        end
        assign cur[g] = chain[SYNC_STAGES-1];
    end

    always_comb begin
        evt.scl_hi   = cur[1];
        evt.sda_bit  = cur[0];
        evt.scl_rise = cur[1] & ~prev[1];
        evt.scl_fall = ~cur[1] & prev[1];
        evt.start_ev = cur[1] & prev[1] & prev[0] & ~cur[0];
        evt.stop_ev  = cur[1] & prev[1] & ~prev[0] & cur[0];
    end

    always_comb begin
        if (!rst) p_events_excl_r7: assert ($onehot0({evt.start_ev, evt.stop_ev}));
    end

endmodule

// File: rtl/i2c_cfg_regbank.sv
module i2c_cfg_regbank
    import i2c_cfg_pkg::*;
#(
    parameter int NUM_REGS = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [BYTE_W-1:0]          wr_idx,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic [BYTE_W-1:0]          rd_idx,
    output logic [BYTE_W-1:0]          rd_data,
    output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
    logic [BYTE_W-1:0] regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                                 regs[i] <= '0;
            else if (wr_en && wr_idx == BYTE_W'(i))  regs[i] <= wr_data;
        end
        assign regs_flat[i*BYTE_W +: BYTE_W] = regs[i];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_idx == BYTE_W'(i)) rd_data = regs[i];
    end

    p_idle_bank_r3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs_flat));
    p_range_write_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx >= BYTE_W'(NUM_REGS)) |=> $stable(regs_flat));

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
    import i2c_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic              addr_sel,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] ptr,
    output logic              sda_oe
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    tgt_state_e        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txreg;
    logic              is_read;
    logic              quiet;

    assign quiet   = ~evt.start_ev & ~evt.stop_ev;
    assign wr_data = {shreg[BYTE_W-2:0], evt.sda_bit};
    assign wr_en   = quiet && state == ST_WDATA && evt.scl_rise && bit_cnt == LAST;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            txreg   <= '0;
            ptr     <= '0;
            is_read <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (evt.start_ev) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else if (evt.stop_ev) begin
            state   <= ST_IDLE;
            sda_oe  <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (evt.scl_rise && bit_cnt < FULL) begin
                        shreg   <= {shreg[BYTE_W-2:0], evt.sda_bit};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (evt.scl_fall && bit_cnt == FULL) begin
                        bit_cnt <= '0;
                        if (state == ST_ADDR) begin
                            if (addr_match(shreg[BYTE_W-1:1], addr_sel)) begin
                                is_read <= shreg[0];
                                state   <= ST_ADDR_ACK;
                                sda_oe  <= 1'b1;
                            end else begin
                                state   <= ST_IDLE;
                            end
                        end else if (state == ST_PTR) begin
                            ptr    <= shreg;
                            state  <= ST_PTR_ACK;
                            sda_oe <= 1'b1;
                        end else begin
                            state  <= ST_WDATA_ACK;
                            sda_oe <= 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK: if (evt.scl_fall) begin
                    if (is_read) begin
                        state   <= ST_RDATA;
                        txreg   <= rd_data;
                        sda_oe  <= ~rd_data[BYTE_W-1];
                        bit_cnt <= '0;
                    end else begin
                        state  <= ST_PTR;
                        sda_oe <= 1'b0;
                    end
                end
                ST_PTR_ACK: if (evt.scl_fall) begin
                    state  <= ST_WDATA;
                    sda_oe <= 1'b0;
                end
                ST_WDATA_ACK: if (evt.scl_fall) begin
                    state  <= ST_IDLE;
                    sda_oe <= 1'b0;
                end
                ST_RDATA: if (evt.scl_fall) begin
                    if (bit_cnt == LAST) begin
                        state   <= ST_RDATA_ACK;
                        sda_oe  <= 1'b0;
                        bit_cnt <= '0;
                    end else begin
                        txreg   <= {txreg[BYTE_W-2:0], 1'b0};
                        sda_oe  <= ~txreg[BYTE_W-2];
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_RDATA_ACK: if (evt.scl_fall) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_start_r7: assert property (@(posedge clk) disable iff (rst)
        evt.start_ev |=> (state == ST_ADDR && !sda_oe));
    p_stop_r7: assert property (@(posedge clk) disable iff (rst)
        (evt.stop_ev && !evt.start_ev) |=> (state == ST_IDLE && !sda_oe));
    p_idle_released_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe);
    p_rd_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (evt.scl_hi && $past(evt.scl_hi) && !$past(evt.start_ev) && !$past(evt.stop_ev))
        |-> $stable(sda_oe));
    p_ptr_kept_r6: assert property (@(posedge clk) disable iff (rst)
        (state != ST_PTR) |=> $stable(ptr));

endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
    import i2c_cfg_pkg::*;
#(
    parameter int NUM_REGS = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       scl_in,
    input  logic                       sda_in,
    input  logic                       addr_sel,
    output logic                       sda_oe,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_regs
);
    bus_evt_t          evt;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] ptr;
    logic [BYTE_W-1:0] rd_data;

    i2c_line_sync #(.SYNC_STAGES(2)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    i2c_byte_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .addr_sel (addr_sel),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ptr      (ptr),
        .sda_oe   (sda_oe)
    );

    i2c_cfg_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (ptr),
        .wr_data   (wr_data),
        .rd_idx    (ptr),
        .rd_data   (rd_data),
        .regs_flat (cfg_regs)
    );

endmodule

// File: tb/test_i2c_cfg_target.sv
`timescale 1ns/1ps
module test_i2c_cfg_target;
    localparam int NREG = 4;
    localparam logic [7:0] W0 = 8'h90, R0 = 8'h91, W1 = 8'h92, R1A = 8'h93;
    localparam logic [15:0] VEC [4] = '{16'h00A5, 16'h013C, 16'h0381, 16'h02FF};

    logic clk = 0, rst = 1, scl_drv = 1, sda_drv = 1, addr_sel = 0;
    logic sda_oe, sda_line;
    logic [NREG*8-1:0] cfg_regs;
    logic [7:0] exp_regs [NREG];
    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;
    assign sda_line = sda_drv & ~sda_oe;

    i2c_cfg_target #(.NUM_REGS(NREG)) i_i2c_cfg_target (
        .clk(clk), .rst(rst), .scl_in(scl_drv), .sda_in(sda_line),
        .addr_sel(addr_sel), .sda_oe(sda_oe), .cfg_regs(cfg_regs));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hp(); repeat (8) @(negedge clk); endtask

    task automatic i2c_start(); sda_drv = 1; scl_drv = 1; hp(); sda_drv = 0; hp(); scl_drv = 0; hp(); endtask
    task automatic i2c_rstart(); sda_drv = 1; hp(); scl_drv = 1; hp(); sda_drv = 0; hp(); scl_drv = 0; hp(); endtask
    task automatic i2c_stop(); sda_drv = 0; hp(); scl_drv = 1; hp(); sda_drv = 1; hp(); endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_drv = b[i]; hp(); scl_drv = 1; hp(); scl_drv = 0; hp();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_drv = 1; hp(); scl_drv = 1; hp();
        ack = ~sda_line;
        scl_drv = 0; hp();
    endtask

    task automatic recv_byte(output logic [7:0] b, output logic stable);
        logic s1, s2;
        stable = 1; b = '0;
        for (int i = 0; i < 8; i++) begin
            scl_drv = 1; repeat (2) @(negedge clk); s1 = sda_line;
            repeat (5) @(negedge clk); s2 = sda_line;
            @(negedge clk); scl_drv = 0; hp();
            b = {b[6:0], s1};
            if (s1 !== s2) stable = 0;
        end
        sda_drv = 1; hp(); scl_drv = 1; hp(); scl_drv = 0; hp();
    endtask

    task automatic wr_reg(input logic [7:0] adr, input logic [7:0] p, input logic [7:0] d,
                          output logic [2:0] acks);
        i2c_start();
        send_byte(adr, acks[2]); send_byte(p, acks[1]); send_byte(d, acks[0]);
        i2c_stop();
    endtask

    task automatic rd_reg(input logic [7:0] p, output logic [7:0] d, output logic stable);
        logic a;
        i2c_start(); send_byte(W0, a); send_byte(p, a);
        i2c_rstart(); send_byte(R0, a);
        recv_byte(d, stable);
    endtask

    function automatic logic [7:0] slice(input logic [NREG*8-1:0] v, input int i);
        return v[i*8 +: 8];
    endfunction

    task automatic chk_bank(input string req);
        for (int i = 0; i < NREG; i++) chk(req, slice(cfg_regs, i), exp_regs[i]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [2:0] acks;
        logic [7:0] d;
        logic st, a;
        for (int i = 0; i < NREG; i++) exp_regs[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 0; hp();

        // R1: reset state
        chk("R1 regs", cfg_regs, '0);
        chk("R1 sda_oe", sda_oe, 0);

        // Table walk: write each vector, then read it back (R2, R4, R5, R9)
        for (int v = 0; v < 4; v++) begin
            wr_reg(W0, VEC[v][15:8], VEC[v][7:0], acks);
            exp_regs[VEC[v][9:8]] = VEC[v][7:0];
            chk("R2/R4 acks", acks, 3'b111);
            chk("R4 stored", slice(cfg_regs, VEC[v][9:8]), VEC[v][7:0]);
            rd_reg(VEC[v][15:8], d, st);
            i2c_stop();
            chk("R5 read data", d, VEC[v][7:0]);
            chk("R9 stable while SCL high", st, 1);
        end
        chk_bank("R4 bank");

        // R6: repeated re-read without resending pointer
        rd_reg(8'h01, d, st);
        chk("R5 read reg1", d, exp_regs[1]);
        for (int k = 0; k < 2; k++) begin
            i2c_rstart(); send_byte(R0, a);
            chk("R6 reread ack", a, 1);
            recv_byte(d, st);
            chk("R6 same register", d, exp_regs[1]);
        end
        i2c_stop();

        // R10: read, then repeated start into a write
        rd_reg(8'h00, d, st);
        chk("R10 read first", d, exp_regs[0]);
        i2c_rstart(); send_byte(W0, acks[2]); send_byte(8'h03, acks[1]); send_byte(8'h11, acks[0]);
        i2c_stop();
        exp_regs[3] = 8'h11;
        chk("R10 acks", acks, 3'b111);
        chk("R10 written", slice(cfg_regs, 3), 8'h11);

        // R3: foreign address ignored
        wr_reg(W1, 8'h00, 8'h00, acks);
        chk("R3 no acks", acks, 3'b000);
        chk("R3 sda released", sda_oe, 0);
        chk_bank("R3 bank unchanged");

        // R2: address select pin moves the address
        addr_sel = 1; hp();
        wr_reg(W1, 8'h02, 8'h5A, acks);
        exp_regs[2] = 8'h5A;
        chk("R2 sel=1 acks", acks, 3'b111);
        chk("R2 sel=1 stored", slice(cfg_regs, 2), 8'h5A);
        wr_reg(W0, 8'h02, 8'h00, acks);
        chk("R2 old address refused", acks, 3'b000);
        chk("R2 bank unchanged", slice(cfg_regs, 2), 8'h5A);
        i2c_start(); send_byte(W1, a); send_byte(8'h02, a);
        i2c_rstart(); send_byte(R1A, a); recv_byte(d, st); i2c_stop();
        chk("R2 sel=1 read", d, 8'h5A);
        addr_sel = 0; hp();

        // R8: pointer beyond the bank
        wr_reg(W0, 8'h09, 8'h77, acks);
        chk("R8 acks", acks, 3'b111);
        chk_bank("R8 write ignored");
        wr_reg(W0, 8'h04, 8'h66, acks);
        chk_bank("R8 boundary write ignored");
        rd_reg(8'h09, d, st); i2c_stop();
        chk("R8 read zero", d, 8'h00);

        // R7: stop in the middle of the data byte
        i2c_start(); send_byte(W0, a); send_byte(8'h01, a);
        send_bits(8'hFF, 5);
        i2c_stop();
        chk("R7 sda released after stop", sda_oe, 0);
        chk_bank("R7 abandoned write");
        wr_reg(W0, 8'h01, 8'hC3, acks);
        exp_regs[1] = 8'hC3;
        chk("R7 next transaction acks", acks, 3'b111);
        chk("R7 next transaction stored", slice(cfg_regs, 1), 8'hC3);

        // R1: reset clears the bank again
        rst = 1; repeat (3) @(negedge clk); rst = 0; hp();
        chk("R1 regs after reset", cfg_regs, '0);
        rd_reg(8'h01, d, st); i2c_stop();
        chk("R1 read after reset", d, 8'h00);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule